// File: doc/BRIEF.md
# Edge-Event Interrupt Aggregator

This block collects eight event sources and turns them into an 8-bit interrupt request vector for a processor. Line 0 carries the timer event, line 1 the serial-port event, and lines 2 to 7 carry six external user interrupt inputs. Every source arrives as a level. A high-to-low transition of that level is captured as a sticky pending event. Software can mask each pending event with an enable bit and acknowledges it by writing a one to it.

Software reaches the registers through a 32-bit memory-mapped port. The port accepts a single-cycle request and returns read data one cycle later. Each source owns a 16-byte slot. The slot holds three registers at consecutive word offsets: the live level (read-only), the pending flag (write-1-to-clear) and the enable flag. The user inputs are treated as asynchronous and are resynchronised before edge detection. The timer and serial sources are taken as already synchronous to the clock.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pending and enable bit reads 0 and `irq_o` is all zeros.
- R2: The status register (slot offset 0x0, bit 0) returns the source's current level, taken after the synchronizer for user inputs. A write to it changes nothing.
- R3: A 1-to-0 transition of a source level sets that source's pending bit (slot offset 0x4, bit 0). A 0-to-1 transition, or a level that stays low, sets nothing.
- R4: Writing 1 in bit 0 of a pending register clears it. Writing 0 leaves it unchanged.
- R5: `irq_o[k]` is a register equal to pending AND enable (enable at slot offset 0x8, bit 0) of source k one cycle earlier. A cleared enable bit therefore keeps the line low.
- R6: When a new falling edge and a write-1-to-clear hit the same source in the same cycle, the pending bit stays set.
- R7: Source index 0 is `timer_evt_i`, index 1 is `serial_evt_i`, and index 2+n is `user_irq_i[n]` for n in 0..5.
- R8: Each user input passes through a two-flop synchronizer. A user falling edge raises its `irq_o` bit two cycles later than a timer falling edge driven in the same cycle.
- R9: Source k's slot starts at byte address k*16. Read data appears on `rsp_rdata` in the cycle after the request. Offset 0xC, and every slot of index 8 or higher, reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_evt_i | input | 1 | Timer event level (source 0) |
| serial_evt_i | input | 1 | Serial-port event level (source 1) |
| user_irq_i | input | 6 | Asynchronous user interrupt levels (sources 2..7) |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| irq_o | output | 8 | Interrupt request vector |

## Verification
The hardest case to reach from the ports is a falling edge and an acknowledge write landing in the same clock cycle. In that case the set must win. The bench first leaves the timer's pending flag set and returns the line high. Then, on one falling clock phase, it drops the timer line and issues the clear write together, and reads the flag back afterwards. The synchronizer latency is checked by dropping a user line and the timer line in the same phase and sampling the interrupt vector on each of the following cycles.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and register-select encoding for the
// edge-event interrupt aggregator. Assumes one event bit per source.
package evt_irq_pkg;
    localparam int SLOT_BYTES = 16;
    localparam int DATA_W     = 32;

    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_PEND   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is independent (no bus coherency is needed).
module evt_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled levels down the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/evt_source.sv
`timescale 1ns/1ps
// Module: one event slot. Detects falling edges of a synchronous level,
// holds a sticky pending flag, holds an enable flag and drives a
// registered request. Assumes lvl_i is already synchronous to clk.
module evt_source (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_wr_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    output logic pend_o,
    output logic en_o,
    output logic req_o
);
    logic lvl_q;
    logic pend_q;
    logic en_q;
    logic req_q;
    logic fall_w;

    assign fall_w = lvl_q & ~lvl_i;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Sticky pending flag; a new edge beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= fall_w | (pend_q & ~clr_wr_i);
    end

    // Enable flag written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_wr_i) en_q <= en_val_i;
    end

    // Registered request line.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= pend_q & en_q;
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign req_o  = req_q;

    AST_PEND_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q && !lvl_i) |=> pend_q); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(lvl_q && !lvl_i)) |=> !pend_q); // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !(lvl_q && !lvl_i)) |=> !pend_q); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && lvl_q && !lvl_i) |=> pend_q); // R6
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && en_q) |=> req_q); // R5
    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q) |=> !req_q); // R5
endmodule

// File: rtl/evt_regbus.sv
`timescale 1ns/1ps
// Module: register decode and read mux for the event slots. Each slot is
// SLOT_BYTES wide; word 0 level, word 1 pending (W1C), word 2 enable.
// Assumes single-cycle requests; read data is registered.
module evt_regbus
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] clr_wr_o,
    output logic [NUM_SRC-1:0] en_wr_o,
    output logic               wr_bit_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int IDX_LSB = $clog2(SLOT_BYTES);
    localparam int IDX_W   = ADDR_W - IDX_LSB;

    logic [IDX_W-1:0]  idx_w;
    reg_sel_e          sel_w;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_bits;

    assign idx_w       = req_addr[ADDR_W-1:IDX_LSB];
    assign sel_w       = reg_sel_e'(req_addr[3:2]);
    assign wr_bit_o    = req_wdata[0];
    assign unused_bits = ^{req_wdata[DATA_W-1:1], req_addr[1:0]};

    // Decode write strobes for each slot.
    always_comb begin
        clr_wr_o = '0;
        en_wr_o  = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (req_valid && req_write && (int'(idx_w) == k)) begin
                clr_wr_o[k] = (sel_w == SEL_PEND) && req_wdata[0];
                en_wr_o[k]  = (sel_w == SEL_ENABLE);
            end
        end
    end

    // Select the read value for the addressed slot and word.
    always_comb begin
        rd_d = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (int'(idx_w) == k) begin
                case (sel_w)
                    SEL_LEVEL:  rd_d[0] = lvl_i[k];
                    SEL_PEND:   rd_d[0] = pend_i[k];
                    SEL_ENABLE: rd_d[0] = en_i[k];
                    default:    rd_d    = '0;
                endcase
            end
        end
    end

    // Register read data on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rdata_q <= '0;
        else if (req_valid && !req_write) rdata_q <= rd_d;
    end

    assign rdata_o = rdata_q;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_wr_o, en_wr_o})); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (int'(idx_w) >= NUM_SRC)) |=> (rdata_o == '0)); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[DATA_W-1:1] == '0)); // R9
endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
// Module: top of the edge-event interrupt aggregator. Source 0 is the
// timer, source 1 the serial port, sources 2.. the user inputs, which
// are resynchronised. Assumes timer/serial levels are synchronous to clk.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int NUM_USER    = 6,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      timer_evt_i,
    input  logic                      serial_evt_i,
    input  logic [NUM_USER-1:0]       user_irq_i,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NUM_USER+1:0]       irq_o
);
    localparam int NUM_SRC = NUM_USER + 2;

    logic [NUM_USER-1:0] user_sync_w;
    logic [NUM_SRC-1:0]  lvl_w;
    logic [NUM_SRC-1:0]  pend_w;
    logic [NUM_SRC-1:0]  en_w;
    logic [NUM_SRC-1:0]  clr_wr_w;
    logic [NUM_SRC-1:0]  en_wr_w;
    logic                wr_bit_w;

    evt_sync #(.WIDTH(NUM_USER), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (user_irq_i),
        .sync_o  (user_sync_w)
    );

    assign lvl_w = {user_sync_w, serial_evt_i, timer_evt_i};

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        evt_source u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (lvl_w[k]),
            .clr_wr_i (clr_wr_w[k]),
            .en_wr_i  (en_wr_w[k]),
            .en_val_i (wr_bit_w),
            .pend_o   (pend_w[k]),
            .en_o     (en_w[k]),
            .req_o    (irq_o[k])
        );
    end

    evt_regbus #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lvl_i     (lvl_w),
        .pend_i    (pend_w),
        .en_i      (en_w),
        .clr_wr_o  (clr_wr_w),
        .en_wr_o   (en_wr_w),
        .wr_bit_o  (wr_bit_w),
        .rdata_o   (rsp_rdata)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_o == '0)); // R1
    AST_USER_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_sync_w[0]) |-> $past(!user_irq_i[0], 2)); // R8
endmodule

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_evt_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_evt_i = 1'b1;
    logic        serial_evt_i = 1'b1;
    logic [5:0]  user_irq_i = 6'h3F;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [7:0]  irq_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .timer_evt_i(timer_evt_i), .serial_evt_i(serial_evt_i),
        .user_irq_i(user_irq_i),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    // Level vector order: {user[5:0], serial, timer}; expected irq_o.
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'hFE, 8'h01}, {8'hFF, 8'h00}, {8'hFD, 8'h02}, {8'hFF, 8'h00},
        {8'h7B, 8'h84}, {8'hFF, 8'h00}, {8'h00, 8'hFF}, {8'h00, 8'h00},
        {8'hFF, 8'h00}, {8'hAA, 8'h55}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_levels(input logic [7:0] lv);
        timer_evt_i  = lv[0];
        serial_evt_i = lv[1];
        user_irq_i   = lv[7:2];
    endtask

    // Both tasks start at a falling clock edge and return at one.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 8; k++) bus_write(8'(k*16 + 4), 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: quiet after reset
        chk("R1 irq", {24'h0, irq_o}, 32'h0);
        bus_read(8'h04, rd); chk("R1 pend0", rd, 32'h0);
        bus_read(8'h78, rd); chk("R1 en7", rd, 32'h0);

        for (int k = 0; k < 8; k++) bus_write(8'(k*16 + 8), 32'h1);
        // R9: enable readback at slot 2 offset 8
        bus_read(8'h28, rd); chk("R9 en2 readback", rd, 32'h1);
        bus_read(8'h2C, rd); chk("R9 offset C zero", rd, 32'h0);
        bus_read(8'h90, rd); chk("R9 unmapped slot", rd, 32'h0);

        // R3 R5 R7: table of level patterns
        for (int v = 0; v < NVEC; v++) begin
            set_levels(VEC[v][15:8]);
            repeat (6) @(negedge clk);
            chk($sformatf("R3/R7 vec%0d", v), {24'h0, irq_o}, {24'h0, VEC[v][7:0]});
            clear_all();
            repeat (2) @(negedge clk);
        end
        set_levels(8'hFF);
        repeat (6) @(negedge clk);
        clear_all();
        repeat (2) @(negedge clk);

        // R2: status shows the level and ignores writes
        timer_evt_i = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(8'h00, rd); chk("R2 timer low", rd, 32'h0);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, rd); chk("R2 status write ignored", rd, 32'h0);
        timer_evt_i = 1'b1;
        @(negedge clk);
        bus_read(8'h00, rd); chk("R2 timer high", rd, 32'h1);

        // R4: write 0 keeps pending, write 1 clears
        bus_read(8'h04, rd); chk("R4 pend set", rd, 32'h1);
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, rd); chk("R4 write0 keeps", rd, 32'h1);
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, rd); chk("R4 write1 clears", rd, 32'h0);

        // R5: mask and one-cycle latency after enable write
        bus_write(8'h08, 32'h0);
        timer_evt_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 masked", {31'h0, irq_o[0]}, 32'h0);
        bus_write(8'h08, 32'h1);
        chk("R5 not yet", {31'h0, irq_o[0]}, 32'h0);
        @(negedge clk);
        chk("R5 raised", {31'h0, irq_o[0]}, 32'h1);

        // R6: edge and clear in the same cycle, set wins
        timer_evt_i = 1'b1;
        repeat (2) @(negedge clk);
        timer_evt_i = 1'b0;
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, rd); chk("R6 set wins", rd, 32'h1);
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, rd); chk("R6 later clear", rd, 32'h0);
        timer_evt_i = 1'b1;
        repeat (3) @(negedge clk);

        // R8: user line lags timer by two cycles; status after sync
        timer_evt_i = 1'b0;
        user_irq_i[0] = 1'b0;
        bus_read(8'h20, rd); chk("R8 status before sync", rd, 32'h1);
        chk("R8 timer irq", {31'h0, irq_o[0]}, 32'h0);
        @(negedge clk);
        chk("R8 timer irq up", {31'h0, irq_o[0]}, 32'h1);
        chk("R8 user still low", {31'h0, irq_o[2]}, 32'h0);
        @(negedge clk);
        chk("R8 user one cycle", {31'h0, irq_o[2]}, 32'h0);
        @(negedge clk);
        chk("R8 user up", {31'h0, irq_o[2]}, 32'h1);
        bus_read(8'h20, rd); chk("R2 user status synced", rd, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule